// File: doc/BRIEF.md
# Serial Odd-Ones / Zeros-Multiple-of-Three Detector

This block watches a serial stream of single bits and flags the moments when the stream so far holds an odd number of ones and a number of zeros that is a multiple of three. Two small residues make up its state. One is the count of ones modulo two. The other is the count of zeros modulo three. Together they give six reachable states. An input-valid qualifier marks which cycles carry a real bit. The state moves only on qualified cycles.

The flag is a Mealy output. It is formed in the same cycle as the bit that completes the condition, from the stored residues and the present input, so no register stands between the input and the flag. The two moduli are parameters. With the defaults, the zeros residue uses a 2-bit code in which one value can never be reached. If the register ever holds that value, the block falls back to its initial state.

Top module: `parity_mod_detector`

## Requirements
- R1: After a synchronous reset, both residues are zero. A first qualified bit of 1 therefore raises `hit_out` in that same cycle.
- R2: A qualified bit of 0 steps the zeros residue through 0, 1, 2 and back to 0, and leaves the ones residue unchanged.
- R3: A qualified bit of 1 flips the ones residue and leaves the zeros residue unchanged.
- R4: `hit_out` is 1 exactly when `bit_valid` is 1, `rst` is 0, the ones count that includes the present bit is odd, and the zeros count that includes the present bit is a multiple of three. It is combinational in the present cycle.
- R5: While `bit_valid` is 0, the state holds whatever `bit_in` is, and `hit_out` is 0.
- R6: While `rst` is 1, `hit_out` is 0 and the next state is the initial state, even when a qualified bit is presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | High when `bit_in` carries a bit to count |
| bit_in | input | 1 | Serial data bit |
| hit_out | output | 1 | Mealy flag: odd ones and zeros a multiple of three, counting the present bit |

## Verification
`hit_out` is due in the same cycle as the bit that decides it. The effect of that bit on the stored residues only shows up in the flag of the next qualified cycle. The bench applies each input one nanosecond after a rising edge and reads `hit_out` at the following falling edge. At that point the comparison covers the combinational result for the present bit. The bench's plain integer counts are then advanced, standing for the register update at the next rising edge. Bits that reach the state are checked through the flag on later cycles. This includes bits presented while `bit_valid` is low, and bits presented during reset.

// File: rtl/pd_pkg.sv
package pd_pkg;

    // Default moduli: ones counted modulo 2, zeros counted modulo 3.
    localparam int ONES_MOD_DEF  = 2;
    localparam int ZEROS_MOD_DEF = 3;

    // Width needed to hold a residue 0..mod-1 (at least one bit).
    function automatic int res_width(input int modulus);
        return (modulus > 2) ? $clog2(modulus) : 1;
    endfunction

endpackage

// File: rtl/mod_residue.sv
// Next-residue logic for one modulo counter. The increment is gated by step.
module mod_residue #(
    parameter int MOD = 3,
    parameter int W   = 2
) (
    input  logic [W-1:0] cur,
    input  logic         step,
    output logic [W-1:0] nxt,
    output logic         legal
);

    generate
        if (MOD == (1 << W)) begin : g_pow2
            // Every code is a residue; the natural wrap of the adder does the modulo.
            always_comb begin
                legal = 1'b1;
                nxt   = cur + W'(step);
            end
        end else begin : g_cmp
            // Codes at or above MOD cannot be reached; wrap explicitly.
            always_comb begin
                legal = (cur < W'(MOD));
                if (!step) begin
                    nxt = cur;
                end else if (cur == W'(MOD - 1)) begin
                    nxt = '0;
                end else begin
                    nxt = cur + W'(1);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/hit_decode.sv
// Mealy flag: judged on the residues that include the present bit.
module hit_decode #(
    parameter int OW = 1,
    parameter int ZW = 2
) (
    input  logic          rst,
    input  logic          bit_valid,
    input  logic          state_ok,
    input  logic [OW-1:0] ones_nxt,
    input  logic [ZW-1:0] zeros_nxt,
    output logic          hit
);

    always_comb begin
        hit = !rst && bit_valid && state_ok
              && (ones_nxt != '0) && (zeros_nxt == '0);
    end

endmodule

// File: rtl/parity_mod_detector.sv
module parity_mod_detector
    import pd_pkg::*;
#(
    parameter int ONES_MOD  = ONES_MOD_DEF,
    parameter int ZEROS_MOD = ZEROS_MOD_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_valid,
    input  logic bit_in,
    output logic hit_out
);

    localparam int OW = res_width(ONES_MOD);
    localparam int ZW = res_width(ZEROS_MOD);

    typedef struct packed {
        logic [OW-1:0] ones;
        logic [ZW-1:0] zeros;
    } tally_t;

    localparam tally_t TALLY_INIT = '0;

    tally_t        tally_d, tally_q;
    logic [OW-1:0] ones_nxt;
    logic [ZW-1:0] zeros_nxt;
    logic          ones_ok, zeros_ok, state_ok;

    mod_residue #(.MOD(ONES_MOD), .W(OW)) u_ones (
        .cur   (tally_q.ones),
        .step  (bit_in),
        .nxt   (ones_nxt),
        .legal (ones_ok)
    );

    mod_residue #(.MOD(ZEROS_MOD), .W(ZW)) u_zeros (
        .cur   (tally_q.zeros),
        .step  (!bit_in),
        .nxt   (zeros_nxt),
        .legal (zeros_ok)
    );

    assign state_ok = ones_ok && zeros_ok;

    hit_decode #(.OW(OW), .ZW(ZW)) u_hit (
        .rst       (rst),
        .bit_valid (bit_valid),
        .state_ok  (state_ok),
        .ones_nxt  (ones_nxt),
        .zeros_nxt (zeros_nxt),
        .hit       (hit_out)
    );

    // Next-state process.
    always_comb begin
        tally_d = tally_q;
        if (!state_ok) begin
            tally_d = TALLY_INIT;
        end else if (bit_valid) begin
            tally_d.ones  = ones_nxt;
            tally_d.zeros = zeros_nxt;
        end
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            tally_q <= TALLY_INIT;
        end else begin
            tally_q <= tally_d;
        end
    end

endmodule

// File: rtl/parity_mod_detector_chk.sv
module parity_mod_detector_chk #(
    parameter int ONES_MOD  = 2,
    parameter int ZEROS_MOD = 3,
    parameter int OW        = 1,
    parameter int ZW        = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          bit_valid,
    input logic          bit_in,
    input logic          hit_out,
    input logic [OW-1:0] ones_q,
    input logic [ZW-1:0] zeros_q
);

    // R1
    reset_init_chk: assert property (@(posedge clk)
        rst |=> (ones_q == '0) && (zeros_q == '0));

    // R2
    zero_step_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && !bit_in) |=>
            (ones_q == $past(ones_q)) &&
            (zeros_q == (($past(zeros_q) == ZW'(ZEROS_MOD - 1)) ? '0 : $past(zeros_q) + ZW'(1))));

    // R2
    zero_range_chk: assert property (@(posedge clk) disable iff (rst)
        zeros_q < ZW'(ZEROS_MOD));

    // R3
    one_step_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && bit_in) |=>
            (zeros_q == $past(zeros_q)) &&
            (ones_q == (($past(ones_q) == OW'(ONES_MOD - 1)) ? '0 : $past(ones_q) + OW'(1))));

    // R4
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        hit_out |-> bit_valid);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |=> $stable(ones_q) && $stable(zeros_q));

    // R6
    reset_quiet_chk: assert property (@(posedge clk)
        rst |-> !hit_out);

endmodule

bind parity_mod_detector parity_mod_detector_chk #(
    .ONES_MOD  (ONES_MOD),
    .ZEROS_MOD (ZEROS_MOD),
    .OW        (OW),
    .ZW        (ZW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_valid (bit_valid),
    .bit_in    (bit_in),
    .hit_out   (hit_out),
    .ones_q    (tally_q.ones),
    .zeros_q   (tally_q.zeros)
);

// File: tb/parity_mod_detector_test.sv
`timescale 1ns/1ps
module parity_mod_detector_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic hit_out;

    int checks = 0;
    int fails  = 0;
    int ones_seen  = 0;
    int zeros_seen = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    parity_mod_detector uut (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .hit_out   (hit_out)
    );

    // One cycle: drive after the edge, check the Mealy flag at the falling edge,
    // then advance the reference counts for the capture at the next edge.
    task automatic cycle(input logic r, input logic v, input logic b, input string force_tag);
        logic  exp;
        string tag;
        @(posedge clk);
        #1;
        rst = r; bit_valid = v; bit_in = b;
        @(negedge clk);
        exp = !r && v && (((ones_seen + (b ? 1 : 0)) % 2) == 1)
                      && (((zeros_seen + (b ? 0 : 1)) % 3) == 0);
        if (force_tag != "")  tag = force_tag;
        else if (r)           tag = "R6";
        else if (!v)          tag = "R5";
        else if (exp)         tag = "R4";
        else if (b)           tag = "R3";
        else                  tag = "R2";
        checks++;
        if (hit_out !== exp) begin
            fails++;
            $display("FAIL %s: hit_out=%b expected=%b (ones=%0d zeros=%0d v=%b b=%b)",
                     tag, hit_out, exp, ones_seen, zeros_seen, v, b);
        end
        if (r) begin
            ones_seen = 0; zeros_seen = 0;
        end else if (v) begin
            if (b) ones_seen++;
            else    zeros_seen++;
        end
    endtask

    initial begin
        // R6: reset cycles, including a qualified 1 during reset
        cycle(1, 0, 0, "R6");
        cycle(1, 1, 1, "R6");
        cycle(1, 1, 0, "R6");
        // R1: first qualified 1 after reset raises the flag at once
        cycle(0, 1, 1, "R1");
        // R2: zeros residue walks 1, 2, 0 (flag on the third)
        cycle(0, 1, 0, "R2");
        cycle(0, 1, 0, "R2");
        cycle(0, 1, 0, "R4");
        // R5: idle cycles with both data values, state must hold
        cycle(0, 0, 1, "R5");
        cycle(0, 0, 0, "R5");
        cycle(0, 0, 1, "R5");
        // R3: ones flip with zeros residue unchanged
        cycle(0, 1, 1, "R3");
        cycle(0, 1, 1, "R3");
        cycle(0, 1, 0, "");
        cycle(0, 1, 0, "");
        cycle(0, 1, 1, "");
        cycle(0, 1, 0, "");
        // R6: reset mid-stream with a qualified 1, then R1 again
        cycle(1, 1, 1, "R6");
        cycle(0, 1, 1, "R1");
        cycle(0, 1, 1, "R3");
        // Random streams at several valid densities
        for (int phase = 0; phase < 4; phase++) begin
            for (int k = 0; k < 800; k++) begin
                logic v, b, r;
                v = (($urandom % 4) <= phase);
                b = $urandom % 2;
                r = (($urandom % 200) == 0);
                cycle(r, v, b, "");
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule